// File: doc/BRIEF.md
# I2C Receive Burst Engine

This block is the receive half of an I2C master. Software issues one control write that holds a byte count and a flag that selects NACK on the final byte. The engine then clocks that many bytes in from the bus, most significant bit first. It generates the acknowledge bit on the ninth clock of each byte without any further software action. Each received byte goes into a receive FIFO.

When the last byte of the burst has been stored, a sticky completion flag is set. If the interrupt enable is set, the interrupt output follows the flag. Software then drains the FIFO by popping bytes through the read-out port, and it watches the empty status to know when to stop. Address transmission and the start and stop conditions belong to neighbouring logic.

The master drives SCL with an open-drain style low-drive output. Each half period lasts a parameter number of clocks. SDA is only ever pulled low during the acknowledge bit, and it changes only while SCL is held low.

Top module: `rxb_engine`

## Requirements
- R1: Received bits are assembled most significant bit first, and the bytes are read out of the FIFO in the order they arrived.
- R2: The count field is `ctl_wdata[6:0]`. A count larger than the FIFO depth is reduced to the depth. Exactly that many bytes, each of nine SCL pulses, are clocked.
- R3: `ctl_wdata[7]` = 1 selects NACK on the last byte. On the ninth clock of every other byte, and of the last byte when bit 7 is 0, `sda_drive_low` is 1 (ACK). For a NACKed last byte it stays 0. SDA changes only while SCL has been driven low for at least one cycle. At reset both drive outputs are 0.
- R4: A control write with count 0 starts nothing. No SCL edge follows and the completion flag stays 0.
- R5: A control write while a burst is running is ignored. The burst keeps its original count and NACK setting.
- R6: `done_flag` is set on the clock edge that stores the last byte of the burst. It stays set until `stat_clr`, and a set in the same cycle as `stat_clr` wins. It is 0 after reset.
- R7: `irq` is 1 exactly when `done_flag` is 1 and the enable bit, written through `ien_we`/`ien_wdata`, is 1. It is 0 after reset.
- R8: `rx_empty` is 1 when the FIFO holds no byte. While the FIFO is empty, `rd_data` reads 0 and a pop changes nothing. Otherwise `rd_data` shows the oldest byte and a pop removes it.
- R9: A byte that completes while the FIFO is full is discarded, and the stored bytes are kept unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control write strobe; starts a burst |
| ctl_wdata | input | 8 | [6:0] byte count, [7] NACK last byte |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 1 | Interrupt enable value |
| stat_clr | input | 1 | Clears the completion flag |
| rd_pop | input | 1 | Pops one byte from the FIFO |
| rd_data | output | 8 | Oldest FIFO byte, 0 when empty |
| rx_empty | output | 1 | FIFO empty |
| done_flag | output | 1 | Sticky burst-complete flag |
| irq | output | 1 | Masked completion interrupt |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line |

## Verification
The completion flag can be set and cleared in the same cycle. The bench provokes this by holding `stat_clr` high for a whole burst. It then expects the flag to be visible for exactly one cycle after the last byte lands, and to be 0 on the next cycle. A second coincidence is a byte arriving at a full FIFO. The bench leaves a full FIFO undrained, runs another burst, and then judges the drained contents against an arithmetic model that keeps only the first bytes stored.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
   localparam int BYTE_W      = 8;
   localparam int CNT_FIELD_W = 7;
   localparam int NACK_BIT    = 7;
   localparam logic [3:0] ACK_SLOT = 4'd8;

   typedef enum logic [1:0] {
      SH_IDLE,
      SH_LOW,
      SH_HIGH,
      SH_TAIL
   } sh_state_t;
endpackage

// File: rtl/rxb_sync.sv
module rxb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else if (STAGES == 1) begin : g_single
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b1;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '1;
            else        r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
   parameter int DEPTH = 64,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty
);
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW   = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH == (1 << AW));

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr, wptr_nx, rptr_nx;
   logic [CW-1:0] cnt;
   logic          full, do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   generate
      if (POW2) begin : g_wrap_free
         assign wptr_nx = wptr + 1'b1;
         assign rptr_nx = rptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr_nx;
         if (do_pop)  rptr <= rptr_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign rdata = empty ? '0 : mem[rptr];
endmodule

// File: rtl/rxb_shifter.sv
module rxb_shifter
   import rxb_pkg::*;
#(
   parameter int HALF_PERIOD = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              more,
   input  logic              ack_now,
   input  logic              sda_in,
   output logic              scl_low,
   output logic              sda_low,
   output logic              byte_stb,
   output logic [BYTE_W-1:0] byte_data
);
   localparam int HW = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;

   sh_state_t         state;
   logic [HW-1:0]     cnt;
   logic [3:0]        slot;
   logic [BYTE_W-1:0] shreg;
   logic              sda_s, last_half;

   rxb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
   );

   assign last_half = (cnt == HW'(HALF_PERIOD - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SH_IDLE;
         cnt   <= '0;
         slot  <= '0;
         shreg <= '0;
      end else begin
         case (state)
            SH_IDLE: begin
               if (start) begin
                  state <= SH_LOW;
                  cnt   <= '0;
                  slot  <= '0;
               end
            end
            SH_LOW: begin
               if (last_half) begin
                  state <= SH_HIGH;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SH_HIGH: begin
               if (last_half) begin
                  cnt <= '0;
                  if (slot == ACK_SLOT) begin
                     state <= SH_TAIL;
                  end else begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     slot  <= slot + 1'b1;
                     state <= SH_LOW;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SH_TAIL: begin
               if (cnt == '0) begin
                  cnt <= cnt + 1'b1;
               end else begin
                  cnt  <= '0;
                  slot <= '0;
                  state <= more ? SH_LOW : SH_IDLE;
               end
            end
            default: state <= SH_IDLE;
         endcase
      end
   end

   assign scl_low   = (state == SH_LOW) || (state == SH_TAIL);
   assign sda_low   = ack_now && (
                        ((state == SH_LOW)  && (slot == ACK_SLOT) && (cnt != '0)) ||
                        ((state == SH_HIGH) && (slot == ACK_SLOT)) ||
                        ((state == SH_TAIL) && (cnt == '0)));
   assign byte_stb  = (state == SH_TAIL) && (cnt != '0);
   assign byte_data = shreg;
endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
   import rxb_pkg::*;
#(
   parameter int DEPTH = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ctl_we,
   input  logic [BYTE_W-1:0]            ctl_wdata,
   input  logic                         ien_we,
   input  logic                         ien_wdata,
   input  logic                         stat_clr,
   input  logic                         byte_stb,
   output logic                         start,
   output logic                         more,
   output logic                         ack_now,
   output logic                         active,
   output logic [$clog2(DEPTH+1)-1:0]   remaining,
   output logic                         done,
   output logic                         irq
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [CNT_FIELD_W-1:0] field;
   logic [CW-1:0]          eff;
   logic                   nack_last, ien, last_byte;

   assign field     = ctl_wdata[CNT_FIELD_W-1:0];
   assign eff       = (field > CNT_FIELD_W'(DEPTH)) ? CW'(DEPTH) : CW'(field);
   assign start     = ctl_we && !active && (field != '0);
   assign last_byte = byte_stb && active && (remaining == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         remaining <= '0;
         nack_last <= 1'b0;
      end else if (start) begin
         active    <= 1'b1;
         remaining <= eff;
         nack_last <= ctl_wdata[NACK_BIT];
      end else if (byte_stb && active) begin
         remaining <= remaining - 1'b1;
         if (remaining == CW'(1)) active <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         done <= 1'b0;
      else if (last_byte) done <= 1'b1;
      else if (stat_clr)  done <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien <= 1'b0;
      else if (ien_we) ien <= ien_wdata;
   end

   assign more    = (remaining > CW'(1));
   assign ack_now = !(nack_last && (remaining == CW'(1)));
   assign irq     = done && ien;
endmodule

// File: rtl/rxb_engine.sv
module rxb_engine
   import rxb_pkg::*;
#(
   parameter int DEPTH       = 64,
   parameter int HALF_PERIOD = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_we,
   input  logic [7:0] ctl_wdata,
   input  logic       ien_we,
   input  logic       ien_wdata,
   input  logic       stat_clr,
   input  logic       rd_pop,
   output logic [7:0] rd_data,
   output logic       rx_empty,
   output logic       done_flag,
   output logic       irq,
   output logic       scl_drive_low,
   output logic       sda_drive_low,
   input  logic       sda_in
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || DEPTH > 127) begin : g_bad_depth
         $error("rxb_engine: DEPTH must lie in 2..127");
      end
      if (HALF_PERIOD < 2) begin : g_bad_half
         $error("rxb_engine: HALF_PERIOD must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES >= 2 * HALF_PERIOD - 1) begin : g_bad_sync
         $error("rxb_engine: SYNC_STAGES too deep for the SCL half period");
      end
   endgenerate

   logic              sh_start, sh_more, sh_ack, byte_stb, ctl_active;
   logic [CW-1:0]     ctl_remaining;
   logic [BYTE_W-1:0] byte_data;

   rxb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ien_we(ien_we), .ien_wdata(ien_wdata),
      .stat_clr(stat_clr), .byte_stb(byte_stb),
      .start(sh_start), .more(sh_more), .ack_now(sh_ack),
      .active(ctl_active), .remaining(ctl_remaining),
      .done(done_flag), .irq(irq)
   );

   rxb_shifter #(.HALF_PERIOD(HALF_PERIOD), .SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .start(sh_start), .more(sh_more), .ack_now(sh_ack),
      .sda_in(sda_in),
      .scl_low(scl_drive_low), .sda_low(sda_drive_low),
      .byte_stb(byte_stb), .byte_data(byte_data)
   );

   rxb_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(byte_stb), .wdata(byte_data),
      .pop(rd_pop), .rdata(rd_data), .empty(rx_empty)
   );
endmodule

// File: rtl/rxb_engine_chk.sv
module rxb_engine_chk #(
   parameter int DEPTH = 64,
   parameter int CW    = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ctl_we,
   input logic [7:0]    ctl_wdata,
   input logic          stat_clr,
   input logic          rd_pop,
   input logic          rx_empty,
   input logic          done_flag,
   input logic          scl_drive_low,
   input logic          sda_drive_low,
   input logic          byte_stb,
   input logic          ctl_active,
   input logic [CW-1:0] ctl_remaining
);
   a_r3_sda_moves_under_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_drive_low) |-> (scl_drive_low && $past(scl_drive_low)));

   a_r2_count_within_depth: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_remaining <= CW'(DEPTH));

   a_r4_zero_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_wdata[6:0] == 7'd0 && !ctl_active) |=> !ctl_active);

   a_r5_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_active && ctl_we && !byte_stb) |=> (ctl_remaining == $past(ctl_remaining)));

   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done_flag && !stat_clr) |=> done_flag);

   a_r6_flag_from_last_byte: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> $past(byte_stb));

   a_r8_pop_on_empty_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pop && rx_empty && !byte_stb) |=> rx_empty);
endmodule

bind rxb_engine rxb_engine_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
   .stat_clr(stat_clr), .rd_pop(rd_pop), .rx_empty(rx_empty),
   .done_flag(done_flag), .scl_drive_low(scl_drive_low),
   .sda_drive_low(sda_drive_low), .byte_stb(byte_stb),
   .ctl_active(ctl_active), .ctl_remaining(ctl_remaining)
);

// File: tb/tb_rxb_engine.sv
module tb_rxb_engine;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;
   localparam int HALF       = 3;
   localparam int SYNC       = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic       ien_we = 1'b0;
   logic       ien_wdata = 1'b0;
   logic       stat_clr = 1'b0;
   logic       rd_pop = 1'b0;
   logic [7:0] rd_data;
   logic       rx_empty, done_flag, irq, scl_drive_low, sda_drive_low;
   logic       sda_in = 1'b1;

   int tests = 0;
   int fails = 0;
   int cyc = 0;

   logic [7:0] sbytes [16];
   logic       ack_log [16];
   int         k = 0, idx = 0, falls = 0;
   logic       scl_prev = 1'b1;
   logic       slave_clear = 1'b0;

   logic [7:0] mq [DEPTH];
   int         mq_n = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxb_engine #(.DEPTH(DEPTH), .HALF_PERIOD(HALF), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ien_we(ien_we), .ien_wdata(ien_wdata), .stat_clr(stat_clr),
      .rd_pop(rd_pop), .rd_data(rd_data), .rx_empty(rx_empty),
      .done_flag(done_flag), .irq(irq), .scl_drive_low(scl_drive_low),
      .sda_drive_low(sda_drive_low), .sda_in(sda_in)
   );

   // bus slave model: data on SCL fall, master acknowledge captured on ninth rise
   always @(negedge clk) begin
      logic scl_now;
      scl_now = !scl_drive_low;
      if (slave_clear) begin
         k = 0; idx = 0; falls = 0; sda_in = 1'b1;
      end else begin
         if (scl_prev && !scl_now) begin
            falls++;
            sda_in = (k < 8) ? sbytes[idx][7-k] : 1'b1;
         end
         if (!scl_prev && scl_now) begin
            if (k == 8) begin
               ack_log[idx] = sda_drive_low;
               idx++;
               k = 0;
            end else begin
               k++;
            end
         end
      end
      scl_prev = scl_now;
   end

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL R6 watchdog: actual cycles %0d expected below 150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic check(input int act, input int exp, input string tag);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic burst(input int n, input bit nack, input bit en,
                        input bit meddle, input bit hold_clr);
      int eff, waited;
      eff = (n > DEPTH) ? DEPTH : n;
      for (int i = 0; i < 16; i++) sbytes[i] = 8'(n * 29 + i * 71 + nack * 5 + 3);
      slave_clear = 1'b1;
      repeat (2) @(negedge clk);
      slave_clear = 1'b0;
      ien_we = 1'b1; ien_wdata = en; stat_clr = 1'b1;
      @(negedge clk);
      ien_we = 1'b0; stat_clr = hold_clr;
      ctl_we = 1'b1; ctl_wdata = {nack, 7'(n)};
      @(negedge clk);
      ctl_we = 1'b0;
      if (eff == 0) begin
         repeat (100) @(negedge clk);
         check(done_flag, 0, "R4 zero count sets no flag");
         check(falls, 0, "R4 zero count clocks nothing");
         return;
      end
      if (meddle) begin
         repeat (40) @(negedge clk);
         ctl_we = 1'b1; ctl_wdata = 8'h81;
         @(negedge clk);
         ctl_we = 1'b0;
      end
      waited = 0;
      while (!done_flag && waited < 8000) begin
         @(negedge clk);
         waited++;
      end
      check(done_flag, 1, "R6 flag set at burst end");
      if (hold_clr) begin
         @(negedge clk);
         check(done_flag, 0, "R6 clear applies after set-wins cycle");
         stat_clr = 1'b0;
      end else begin
         check(irq, en, "R7 irq follows flag and enable");
         repeat (3) @(negedge clk);
         check(done_flag, 1, "R6 flag sticky");
      end
      repeat (2 * HALF + 4) @(negedge clk);
      check(idx, eff, "R2 bytes clocked");
      for (int i = 0; i < eff; i++)
         check(ack_log[i], (nack && i == eff - 1) ? 0 : 1, "R3 acknowledge level");
      for (int i = 0; i < eff; i++) begin
         if (mq_n < DEPTH) begin
            mq[mq_n] = sbytes[i];
            mq_n++;
         end
      end
   endtask

   task automatic drain();
      while (mq_n > 0) begin
         check(rx_empty, 0, "R8 not empty while data held");
         check(rd_data, mq[0], "R1 byte order and value");
         rd_pop = 1'b1;
         @(negedge clk);
         rd_pop = 1'b0;
         for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i+1];
         mq_n--;
      end
      check(rx_empty, 1, "R8 empty after drain");
      check(rd_data, 0, "R8 data zero when empty");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check(rx_empty, 1, "R8 empty at reset");
      check(done_flag, 0, "R6 flag clear at reset");
      check(irq, 0, "R7 irq low at reset");
      check(scl_drive_low, 0, "R3 SCL released at reset");
      check(sda_drive_low, 0, "R3 SDA released at reset");
      rst_n = 1'b1;
      @(negedge clk);

      for (int nk = 0; nk < 2; nk++) begin
         for (int n = 0; n <= 10; n++) begin
            burst(n, nk[0], n[0], 1'b0, 1'b0);
            drain();
         end
      end

      // R5: control write in mid-burst
      burst(3, 1'b0, 1'b1, 1'b1, 1'b0);
      drain();

      // R9: bytes arriving at a full FIFO are dropped
      burst(DEPTH, 1'b0, 1'b0, 1'b0, 1'b0);
      burst(2, 1'b1, 1'b0, 1'b0, 1'b0);
      drain();

      // R8: pop on empty leaves the pointers alone
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
      check(rx_empty, 1, "R8 pop on empty keeps empty");
      check(rd_data, 0, "R8 pop on empty reads zero");
      burst(1, 1'b1, 1'b1, 1'b0, 1'b0);
      drain();

      // R6: clear held across the set cycle
      burst(4, 1'b0, 1'b0, 1'b0, 1'b1);
      drain();

      summary();
      $finish;
   end
endmodule